// File: doc/BRIEF.md
# Out-of-Order Issue Core with Tag Broadcast

This block is the scheduling heart of a small arithmetic unit that executes out of order. It takes instructions one at a time, in program order, and parks each in a reservation station of the right kind: three stations serve add and subtract, and two serve multiply and divide. When it parks an instruction, the block renames its destination register to the station's tag. Each source operand arrives either as a value or as the tag of the station that will produce it.

A station runs its operation once both operands are present. Each station counts out a fixed execution latency of its own. Finished results go through a fixed-priority arbiter onto a single registered result bus that carries a tag and 64 bits of data. Every waiting station and every register whose pending tag matches the bus tag picks up the value. Because only the latest writer of a register owns it, write-after-read and write-after-write conflicts disappear, and the final register contents equal those of plain sequential execution.

A registered read port shows any register's value and whether a write to it is still pending. Surrounding logic uses this port to observe results.

Top module: `tomo_core`

## Requirements
- R1: After all issued instructions have finished, every register holds the value that strictly sequential execution of the same instruction stream would give, and no register shows a pending write.
- R2: `iss_ready` is high exactly when a station of the needed kind is free. Op codes 0 and 1 use the add stations, which carry tags 1 to 3. Op codes 2 and 3 use the multiply stations, which carry tags 4 and 5. The lowest-numbered free station is chosen, and an instruction offered while `iss_ready` is low is held and not taken.
- R3: When an instruction is accepted, each source takes the register value if no write to that register is pending, and otherwise takes the pending tag. The destination then becomes pending on the new station's tag, and `rd_pending` shows this on a read made after the issuing edge.
- R4: A broadcast updates a register only when that register's pending tag still equals the broadcast tag. An older producer finishing after a younger writer to the same register leaves that register untouched.
- R5: A station begins counting its latency only once both operands are present. With both operands present at issue, the result appears on the bus in the cycle after the (L+1)-th clock edge following the issuing edge. L is 2 for add and subtract, 10 for multiply and 40 for divide.
- R6: The bus (`cdb_valid`, `cdb_tag`, `cdb_data`) is registered and carries at most one result per cycle. On the edge that ends a broadcast cycle, every station operand and every register waiting on that tag captures the data.
- R7: An instruction accepted on the same edge on which its source's producer is being broadcast takes the broadcast value rather than the tag. It then reaches the bus L+1 edges after issue, with no extra wait.
- R8: When several stations finish in the same cycle, the one with the lowest tag is granted the bus first. The others keep their results and are granted in later cycles.
- R9: A station is freed on the edge that puts its result on the bus, so `iss_ready` for its kind is high during that broadcast cycle.
- R10: Op code 0 adds, 1 subtracts (first minus second), 2 multiplies (lower 64 bits) and 3 divides unsigned (first by second). A divide by zero yields all ones.
- R11: After reset, register k holds k+1, no write is pending, all stations are free and `cdb_valid` is low. The read port returns the register state as it stood before the clock edge that follows `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_op | input | 2 | Operation code |
| iss_dst | input | 3 | Destination register index |
| iss_src1 | input | 3 | First source register index |
| iss_src2 | input | 3 | Second source register index |
| iss_ready | output | 1 | A station of the needed kind is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 4 | Tag of the broadcasting station |
| cdb_data | output | 64 | Broadcast result |
| rd_idx | input | 3 | Register index to observe |
| rd_data | output | 64 | Registered value of the observed register |
| rd_pending | output | 1 | Registered flag: a write to the observed register is pending |

## Verification
Two collisions matter most. The first is issue and broadcast on the same edge: the bench waits until a producer's tag is on the bus and offers a consumer of it at that moment. It then checks that the consumer reaches the bus with no added delay and that the final register value matches sequential execution. The second is several stations finishing in the same cycle: one multiply feeds two adds, and the bench checks that their results leave in tag order on consecutive cycles. A behavioural model in the bench, fed with random streams, compares the bus, the ready flag and the read port on every cycle.

// File: rtl/tomo_pkg.sv
package tomo_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  function automatic logic uses_mul_unit(op_e o);
    return (o == OP_MUL) || (o == OP_DIV);
  endfunction
endpackage

// File: rtl/tomo_station.sv
module tomo_station
  import tomo_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 4,
  parameter bit IS_MUL  = 1'b0,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  op_e               ld_op,
  input  logic [DATA_W-1:0] ld_vj,
  input  logic [TAG_W-1:0]  ld_qj,
  input  logic [DATA_W-1:0] ld_vk,
  input  logic [TAG_W-1:0]  ld_qk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              grant,
  output logic              busy,
  output logic              req,
  output logic [DATA_W-1:0] result
);
  localparam int LMAX0 = (LAT_ADD > LAT_MUL) ? LAT_ADD : LAT_MUL;
  localparam int LMAX  = (LMAX0 > LAT_DIV) ? LMAX0 : LAT_DIV;
  localparam int CW    = $clog2(LMAX + 1);

  op_e               op_q;
  logic [DATA_W-1:0] vj_q, vk_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [CW-1:0]     cnt_q;
  logic              opnd_rdy;

  function automatic logic [CW-1:0] lat_of(op_e o);
    case (o)
      OP_MUL:  return CW'(LAT_MUL);
      OP_DIV:  return CW'(LAT_DIV);
      default: return CW'(LAT_ADD);
    endcase
  endfunction

  assign opnd_rdy = (qj_q == '0) && (qk_q == '0);
  assign req      = busy && opnd_rdy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      op_q  <= OP_ADD;
      vj_q  <= '0;
      vk_q  <= '0;
      qj_q  <= '0;
      qk_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      op_q  <= ld_op;
      vj_q  <= ld_vj;
      vk_q  <= ld_vk;
      qj_q  <= ld_qj;
      qk_q  <= ld_qk;
      cnt_q <= lat_of(ld_op);
    end else if (busy) begin
      if (grant) busy <= 1'b0;
      if (qj_q != '0 && cdb_valid && cdb_tag == qj_q) begin
        vj_q <= cdb_data;
        qj_q <= '0;
      end
      if (qk_q != '0 && cdb_valid && cdb_tag == qk_q) begin
        vk_q <= cdb_data;
        qk_q <= '0;
      end
      if (opnd_rdy && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  generate
    if (IS_MUL) begin : g_mul
      always_comb begin
        if (op_q == OP_DIV) result = (vk_q == '0) ? '1 : (vj_q / vk_q);
        else                result = vj_q * vk_q;
      end
    end else begin : g_add
      always_comb begin
        if (op_q == OP_SUB) result = vj_q - vk_q;
        else                result = vj_q + vk_q;
      end
    end
  endgenerate

  // once an operand is present it stays present until the station is freed
  assert_operand_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && qj_q == '0) |=> (!busy || qj_q == '0));
  // a granted station is free on the next cycle
  assert_free_after_grant_R9: assert property (@(posedge clk) disable iff (rst)
    grant |=> !busy);
  // a station never loads while it still holds an instruction
  assert_no_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/tomo_regfile.sv
module tomo_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              iss_fire,
  input  logic [RIDX_W-1:0] iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [RIDX_W-1:0] src1,
  input  logic [RIDX_W-1:0] src2,
  output logic [DATA_W-1:0] s1_val,
  output logic [TAG_W-1:0]  s1_tag,
  output logic [DATA_W-1:0] s2_val,
  output logic [TAG_W-1:0]  s2_tag,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pending
);
  logic [DATA_W-1:0] rf [NREG];
  logic [TAG_W-1:0]  qi [NREG];
  logic [TAG_W-1:0]  q1, q2;

  assign q1 = qi[src1];
  assign q2 = qi[src2];

  always_comb begin
    s1_val = '0;
    s1_tag = '0;
    if (q1 == '0)                          s1_val = rf[src1];
    else if (cdb_valid && cdb_tag == q1)   s1_val = cdb_data;
    else                                   s1_tag = q1;
    s2_val = '0;
    s2_tag = '0;
    if (q2 == '0)                          s2_val = rf[src2];
    else if (cdb_valid && cdb_tag == q2)   s2_val = cdb_data;
    else                                   s2_tag = q2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_pending <= 1'b0;
    end else begin
      rd_data    <= rf[rd_idx];
      rd_pending <= (qi[rd_idx] != '0);
    end
  end

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          rf[r] <= DATA_W'(r + 1);
          qi[r] <= '0;
        end else begin
          if (cdb_valid && qi[r] != '0 && qi[r] == cdb_tag) begin
            rf[r] <= cdb_data;
            qi[r] <= '0;
          end
          if (iss_fire && iss_dst == RIDX_W'(r)) qi[r] <= iss_tag;
        end
      end

      assert_rename_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_fire && iss_dst == RIDX_W'(r)) |=> qi[r] == $past(iss_tag));
      assert_owner_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (cdb_valid && qi[r] != '0 && qi[r] != cdb_tag &&
         !(iss_fire && iss_dst == RIDX_W'(r)))
        |=> (qi[r] == $past(qi[r]) && rf[r] == $past(rf[r])));
      assert_writeback_R6: assert property (@(posedge clk) disable iff (rst)
        (cdb_valid && qi[r] != '0 && qi[r] == cdb_tag &&
         !(iss_fire && iss_dst == RIDX_W'(r)))
        |=> (qi[r] == '0 && rf[r] == $past(cdb_data)));
    end
  endgenerate
endmodule

// File: rtl/tomo_cdb_arb.sv
module tomo_cdb_arb #(
  parameter int NST    = 5,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NST-1:0]               req,
  input  logic [NST-1:0][DATA_W-1:0]   res,
  output logic [NST-1:0]               grant,
  output logic                         cdb_valid,
  output logic [TAG_W-1:0]             cdb_tag,
  output logic [DATA_W-1:0]            cdb_data
);
  logic              found;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    grant    = '0;
    found    = 1'b0;
    sel_tag  = '0;
    sel_data = '0;
    for (int i = 0; i < NST; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        sel_tag  = TAG_W'(i + 1);
        sel_data = res[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cdb_valid <= 1'b0;
      cdb_tag   <= '0;
      cdb_data  <= '0;
    end else begin
      cdb_valid <= found;
      cdb_tag   <= sel_tag;
      cdb_data  <= sel_data;
    end
  end

  assert_grant_to_req_R8: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_work_conserving_R8: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> cdb_valid);

  generate
    for (genvar i = 0; i < NST; i++) begin : g_hold
      assert_loser_waits_R8: assert property (@(posedge clk) disable iff (rst)
        (req[i] && !grant[i]) |=> req[i]);
    end
  endgenerate
endmodule

// File: rtl/tomo_core.sv
module tomo_core
  import tomo_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 4,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40,
  localparam int NST    = N_ADD + N_MUL,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic [RIDX_W-1:0] iss_dst,
  input  logic [RIDX_W-1:0] iss_src1,
  input  logic [RIDX_W-1:0] iss_src2,
  output logic              iss_ready,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_data,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pending
);
  op_e                        op_in;
  logic                       want_mul;
  logic                       iss_fire;
  logic [TAG_W-1:0]           alloc_tag;
  logic [NST-1:0]             st_busy, st_req, st_grant, st_load;
  logic [NST-1:0][DATA_W-1:0] st_res;
  logic [DATA_W-1:0]          s1_val, s2_val;
  logic [TAG_W-1:0]           s1_tag, s2_tag;

  assign op_in    = op_e'(iss_op);
  assign want_mul = uses_mul_unit(op_in);

  always_comb begin
    iss_ready = 1'b0;
    alloc_tag = '0;
    for (int i = 0; i < NST; i++) begin
      if (!iss_ready && !st_busy[i] && ((i >= N_ADD) == want_mul)) begin
        iss_ready = 1'b1;
        alloc_tag = TAG_W'(i + 1);
      end
    end
  end

  assign iss_fire = iss_valid && iss_ready;

  tomo_regfile #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_regs (
    .clk(clk), .rst(rst),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .iss_fire(iss_fire), .iss_dst(iss_dst), .iss_tag(alloc_tag),
    .src1(iss_src1), .src2(iss_src2),
    .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_pending(rd_pending)
  );

  generate
    for (genvar i = 0; i < NST; i++) begin : g_st
      assign st_load[i] = iss_fire && (alloc_tag == TAG_W'(i + 1));
      tomo_station #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .IS_MUL(i >= N_ADD),
        .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
      ) u_st (
        .clk(clk), .rst(rst), .load(st_load[i]), .ld_op(op_in),
        .ld_vj(s1_val), .ld_qj(s1_tag), .ld_vk(s2_val), .ld_qk(s2_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .grant(st_grant[i]), .busy(st_busy[i]), .req(st_req[i]),
        .result(st_res[i])
      );
    end
  endgenerate

  tomo_cdb_arb #(.NST(NST), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_arb (
    .clk(clk), .rst(rst), .req(st_req), .res(st_res), .grant(st_grant),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  assert_tag_range_R6: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TAG_W'(NST)));
  assert_issue_occupies_R2: assert property (@(posedge clk) disable iff (rst)
    iss_fire |=> (st_busy != '0));
endmodule

// File: tb/test_tomo_core.sv
module test_tomo_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = 2'd0;
  logic [2:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0, rd_idx = '0;
  logic        iss_ready, cdb_valid, rd_pending;
  logic [3:0]  cdb_tag;
  logic [63:0] cdb_data, rd_data;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tomo_core i_tomo_core (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_pending(rd_pending)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] calc(input int op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return (b == 0) ? '1 : a / b;
    endcase
  endfunction

  function automatic int lat(input int op);
    return (op == 2) ? 10 : (op == 3) ? 40 : 2;
  endfunction

  // behavioural reference: five slots, eight registers, one result bus
  logic [63:0] m_rf [8];
  int          m_qi [8];
  bit          m_busy [5];
  int          m_op [5], m_qj [5], m_qk [5], m_cnt [5];
  logic [63:0] m_vj [5], m_vk [5];
  bit          m_cv;
  int          m_ct;
  logic [63:0] m_cd, m_rd;
  bit          m_rp;
  logic [63:0] seq_rf [8];

  function automatic int m_pick(input int op);
    int lo = (op >= 2) ? 3 : 0;
    int hi = (op >= 2) ? 5 : 3;
    for (int s = lo; s < hi; s++) if (!m_busy[s]) return s;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < 8; r++) begin m_rf[r] = 64'(r + 1); m_qi[r] = 0; end
      for (int s = 0; s < 5; s++) begin m_busy[s] = 0; m_qj[s] = 0; m_qk[s] = 0; m_cnt[s] = 0; end
      m_cv = 0; m_ct = 0; m_cd = '0; m_rd = '0; m_rp = 0;
    end else begin
      int pick, win, t1, t2;
      logic [63:0] v1, v2, wd;
      pick = iss_valid ? m_pick(int'(iss_op)) : -1;
      m_rd = m_rf[rd_idx];
      m_rp = (m_qi[rd_idx] != 0);
      t1 = m_qi[iss_src1]; v1 = m_rf[iss_src1];
      if (t1 != 0 && m_cv && m_ct == t1) begin v1 = m_cd; t1 = 0; end
      t2 = m_qi[iss_src2]; v2 = m_rf[iss_src2];
      if (t2 != 0 && m_cv && m_ct == t2) begin v2 = m_cd; t2 = 0; end
      win = -1; wd = '0;
      for (int s = 0; s < 5; s++)
        if (win < 0 && m_busy[s] && m_qj[s] == 0 && m_qk[s] == 0 && m_cnt[s] == 0) win = s;
      if (win >= 0) wd = calc(m_op[win], m_vj[win], m_vk[win]);
      for (int s = 0; s < 5; s++)
        if (m_busy[s] && m_qj[s] == 0 && m_qk[s] == 0 && m_cnt[s] > 0) m_cnt[s]--;
      if (m_cv) begin
        for (int s = 0; s < 5; s++) if (m_busy[s]) begin
          if (m_qj[s] == m_ct) begin m_vj[s] = m_cd; m_qj[s] = 0; end
          if (m_qk[s] == m_ct) begin m_vk[s] = m_cd; m_qk[s] = 0; end
        end
        for (int r = 0; r < 8; r++) if (m_qi[r] == m_ct) begin m_rf[r] = m_cd; m_qi[r] = 0; end
      end
      if (win >= 0) m_busy[win] = 0;
      m_cv = (win >= 0); m_ct = win + 1; m_cd = wd;
      if (pick >= 0) begin
        m_busy[pick] = 1; m_op[pick] = int'(iss_op);
        m_vj[pick] = t1 == 0 ? v1 : '0; m_qj[pick] = t1;
        m_vk[pick] = t2 == 0 ? v2 : '0; m_qk[pick] = t2;
        m_cnt[pick] = lat(int'(iss_op));
        m_qi[iss_dst] = pick + 1;
      end
    end
  end

  // cycle compare against the reference, away from the edge
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      chk(cdb_valid == m_cv, "R6 cdb_valid", 64'(cdb_valid), 64'(m_cv));
      if (m_cv) begin
        chk(cdb_tag == 4'(m_ct), "R8 cdb_tag", 64'(cdb_tag), 64'(m_ct));
        chk(cdb_data == m_cd, "R6 cdb_data", cdb_data, m_cd);
      end
      chk(iss_ready == (m_pick(int'(iss_op)) >= 0), "R2 iss_ready", 64'(iss_ready), 64'(m_pick(int'(iss_op)) >= 0));
      chk(rd_data == m_rd, "R3 rd_data", rd_data, m_rd);
      chk(rd_pending == m_rp, "R3 rd_pending", 64'(rd_pending), 64'(m_rp));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL R1 watchdog act=%0d exp=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input int op, input int d, input int a, input int b);
    logic [63:0] r;
    iss_valid = 1; iss_op = op[1:0]; iss_dst = d[2:0]; iss_src1 = a[2:0]; iss_src2 = b[2:0];
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    r = calc(op, seq_rf[a], seq_rf[b]);
    seq_rf[d] = r;
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic edges_to_cdb(output int n);
    n = 1; #1;
    while (!cdb_valid) begin @(negedge clk); #1; n++; end
  endtask

  task automatic read_reg(input int k, output logic [63:0] d, output logic p);
    rd_idx = k[2:0];
    @(negedge clk); #1;
    d = rd_data; p = rd_pending;
  endtask

  task automatic drain();
    bit any;
    do begin
      @(negedge clk);
      any = 0;
      for (int s = 0; s < 5; s++) any |= m_busy[s];
    end while (any || m_cv);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int n;
    logic [63:0] d;
    logic p;
    for (int r = 0; r < 8; r++) seq_rf[r] = 64'(r + 1);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R11 reset state
    chk(iss_ready == 1, "R11 ready after reset", 64'(iss_ready), 1);
    chk(cdb_valid == 0, "R11 bus idle after reset", 64'(cdb_valid), 0);
    for (int k = 0; k < 8; k++) begin
      read_reg(k, d, p);
      chk(d == 64'(k + 1) && !p, "R11 reset register", d, 64'(k + 1));
    end
    // R5 latencies with operands present
    issue(0, 1, 2, 3); edges_to_cdb(n);
    chk(n == 4, "R5 add latency", 64'(n), 4); drain();
    issue(2, 4, 2, 3); edges_to_cdb(n);
    chk(n == 12, "R5 mul latency", 64'(n), 12); drain();
    issue(3, 5, 6, 2); edges_to_cdb(n);
    chk(n == 42, "R5 div latency", 64'(n), 42); drain();
    // R3 rename visible, consumer waits on tag
    issue(2, 1, 2, 3);
    read_reg(1, d, p);
    chk(p == 1, "R3 destination pending", 64'(p), 1);
    issue(0, 6, 1, 2);
    drain();
    read_reg(6, d, p);
    chk(d == seq_rf[6], "R6 dependent result", d, seq_rf[6]);
    // R8 two stations finishing together
    issue(2, 1, 3, 4); issue(0, 2, 1, 5); issue(0, 3, 1, 6);
    while (!(cdb_valid && cdb_tag == 4)) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    while (!cdb_valid) begin @(negedge clk); #1; end
    chk(cdb_tag == 1, "R8 lower tag first", 64'(cdb_tag), 1);
    @(negedge clk); #1;
    chk(cdb_valid && cdb_tag == 2, "R8 loser next cycle", 64'(cdb_tag), 2);
    drain();
    // R7 issue on the broadcast edge of its producer
    issue(0, 1, 2, 3);
    while (!(cdb_valid && cdb_tag == 1)) begin @(negedge clk); #1; end
    issue(0, 4, 1, 1); edges_to_cdb(n);
    chk(n == 4, "R7 forwarded source no wait", 64'(n), 4);
    drain();
    read_reg(4, d, p);
    chk(d == seq_rf[4], "R7 forwarded value", d, seq_rf[4]);
    // R4 older producer must not overwrite younger writer
    issue(2, 3, 2, 2); issue(0, 3, 1, 1);
    while (!(cdb_valid && cdb_tag == 1)) begin @(negedge clk); #1; end
    read_reg(3, d, p);
    chk(p == 1, "R4 still owned by younger", 64'(p), 1);
    drain();
    read_reg(3, d, p);
    chk(d == seq_rf[3], "R4 younger value kept", d, seq_rf[3]);
    // R2 and R9 structural stall and release
    issue(3, 1, 2, 3); issue(0, 4, 1, 1); issue(0, 5, 1, 2); issue(0, 6, 1, 3);
    iss_op = 2'd0; #1;
    chk(iss_ready == 0, "R2 add stations full", 64'(iss_ready), 0);
    iss_op = 2'd2; #1;
    chk(iss_ready == 1, "R2 mul station free", 64'(iss_ready), 1);
    iss_op = 2'd0;
    while (!cdb_valid) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    while (!cdb_valid) begin @(negedge clk); #1; end
    chk(cdb_tag == 1 && iss_ready == 1, "R9 freed during broadcast", 64'(iss_ready), 1);
    issue(0, 7, 2, 2);
    drain();
    // R10 divide by zero
    issue(1, 6, 6, 6); issue(3, 7, 7, 6);
    drain();
    read_reg(7, d, p);
    chk(d == '1, "R10 divide by zero", d, '1);
    read_reg(6, d, p);
    chk(d == 0, "R10 subtract", d, 0);
    // R1 random streams against sequential order
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      op = (op < 4) ? 0 : (op < 7) ? 1 : (op < 9) ? 2 : 3;
      issue(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
    end
    drain();
    for (int k = 0; k < 8; k++) begin
      read_reg(k, d, p);
      chk(d == seq_rf[k] && !p, "R1 sequential equivalence", d, seq_rf[k]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule